// File: doc/BRIEF.md
# Modem Handshake Control and Status Register

This block holds the modem handshake lines of a serial port. The host writes a small control register. That register drives four active-low output pins: data-terminal-ready, request-to-send and two auxiliary outputs. It also sets a loopback flag. The host reads back a status byte. Its upper nibble shows the present level of the four handshake inputs: clear-to-send, data-set-ready, ring and carrier detect. Its lower nibble holds sticky change flags.

The external inputs are active low and pass through a two-flop synchronizer. When loopback is on, the status levels come from the control register's own outputs rather than from the pins. In that mode the data-terminal-ready and request-to-send pins are held inactive. The change flags stay set until the host reads the status byte, and that read clears them. The ring flag marks only the end of a ring, not its start. An indication output stays high for as long as any change flag is set.

Top module: `mdm_hs_regs`

## Requirements
- R1: A write stores the low five bits of `wdata` as the control byte. Bits 7..5 are ignored and read back as 0. `rd_sel`=0 returns the control byte on `rdata`, and `rd_sel`=1 returns the status byte.
- R2: When loopback is off, control bit 0 (DTR) = 1 drives `dtr_n` low and bit 1 (RTS) = 1 drives `rts_n` low. Bit 2 drives `out1_n` low and bit 3 drives `out2_n` low. Control bit 4 appears on `loop_en`.
- R3: With control bit 4 set, the status levels are taken from the control bits: CTS from RTS, DSR from DTR, RI from OUT1 and DCD from OUT2. The external inputs have no effect, and `dtr_n` and `rts_n` are held high.
- R4: Status bits 7..4 are the present levels of DCD, RI, DSR and CTS, in that order. A level reads 1 when the line is asserted, meaning the pin is low. An external pin change appears within three clock edges.
- R5: Status bit 3 (DCD), bit 1 (DSR) and bit 0 (CTS) are set when their line changes state one or more times. They stay set until a status read.
- R6: Status bit 2 is set only when the ring pin goes from low to high, which is a level change from 1 to 0. Ring assertion does not set it.
- R7: A status read (`rd_en`=1 with `rd_sel`=1) returns the current flags and clears all four of them. A change seen in that same cycle leaves its flag set.
- R8: `chg_irq` is high exactly when at least one change flag is set.
- R9: After reset the control byte is 0, all four output pins are high, all flags are 0 and `chg_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| rd_en | input | 1 | Read strobe; clears the flags when the status byte is selected |
| rd_sel | input | 1 | 0 selects the control byte, 1 selects the status byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| out1_n | output | 1 | Auxiliary output 1, active low |
| out2_n | output | 1 | Auxiliary output 2, active low |
| loop_en | output | 1 | Loopback flag |
| cts_n | input | 1 | Clear-to-send input, active low |
| dsr_n | input | 1 | Data-set-ready input, active low |
| ri_n | input | 1 | Ring input, active low |
| dcd_n | input | 1 | Carrier-detect input, active low |
| chg_irq | output | 1 | High while any change flag is set |

## Verification
The assertions watch a few properties on every cycle. Flags never drop without a status read. A read with no concurrent change leaves the flags empty. A read that races a change keeps exactly that change. A ring assertion never raises the ring flag, and loopback always parks the two handshake pins. Some behaviours can only be shown by the bench's scenarios, because they depend on the routing of a whole byte through sync, mux and read: the synchronizer latency, the bit positions in the status byte, the lane mapping in loopback, the external pins being ignored in loopback, and the flags raised on entering or leaving loopback.

// File: rtl/mdm_hs_pkg.sv
package mdm_hs_pkg;
  localparam int DATA_W  = 8;
  localparam int LINES   = 4;   // lane index: 0 CTS, 1 DSR, 2 RI, 3 DCD
  localparam int RI_LANE = 2;
  localparam int LOOP_BIT = 4;

  // Writable control bits are the low five; the rest stay zero.
  function automatic logic [DATA_W-1:0] ctrl_mask(input logic [DATA_W-1:0] d);
    return d & DATA_W'(8'h1F);
  endfunction

  // Active-low pin to asserted level.
  function automatic logic [LINES-1:0] pin_level(input logic [LINES-1:0] pins_n);
    return ~pins_n;
  endfunction

  // Change events: any toggle, except the ring lane, which fires only on a 1->0 level drop.
  function automatic logic [LINES-1:0] line_events(input logic [LINES-1:0] cur,
                                                    input logic [LINES-1:0] prev);
    logic [LINES-1:0] ev;
    ev = cur ^ prev;
    ev[RI_LANE] = prev[RI_LANE] & ~cur[RI_LANE];
    return ev;
  endfunction
endpackage

// File: rtl/mdm_hs_sync.sv
module mdm_hs_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;   // pins idle high
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mdm_hs_ctrl.sv
module mdm_hs_ctrl
  import mdm_hs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out1_n,
  output logic              out2_n,
  output logic              loop_on,
  output logic [LINES-1:0]  loop_lvl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_mask(wdata);
  end

  assign loop_on = ctrl_q[LOOP_BIT];
  assign dtr_n   = loop_on | ~ctrl_q[0];
  assign rts_n   = loop_on | ~ctrl_q[1];
  assign out1_n  = ~ctrl_q[2];
  assign out2_n  = ~ctrl_q[3];

  // Internal routing: CTS<-RTS, DSR<-DTR, RI<-OUT1, DCD<-OUT2
  assign loop_lvl = {ctrl_q[3], ctrl_q[2], ctrl_q[0], ctrl_q[1]};

  AST_LOOP_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    loop_on |-> (dtr_n && rts_n)); // R3
endmodule

// File: rtl/mdm_hs_delta.sv
module mdm_hs_delta
  import mdm_hs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] cur_lvl,
  input  logic             rd_clr,
  output logic [LINES-1:0] flags,
  output logic [LINES-1:0] evt
);
  logic [LINES-1:0] prev_lvl;

  assign evt = line_events(cur_lvl, prev_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lvl <= '0;
      flags    <= '0;
    end else begin
      prev_lvl <= cur_lvl;
      flags    <= (rd_clr ? '0 : flags) | evt;
    end
  end

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((flags & $past(flags)) == $past(flags))); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && evt == '0) |=> (flags == '0)); // R7
  AST_READ_RACE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && evt != '0) |=> (flags == $past(evt))); // R7
  AST_RING_LEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_lvl[RI_LANE] && cur_lvl[RI_LANE] && !flags[RI_LANE]) |=> !flags[RI_LANE]); // R6
endmodule

// File: rtl/mdm_hs_regs.sv
module mdm_hs_regs
  import mdm_hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       rd_sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       out1_n,
  output logic       out2_n,
  output logic       loop_en,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  output logic       chg_irq
);
  logic [DATA_W-1:0] ctrl_q;
  logic [LINES-1:0]  loop_lvl, ext_sync_n, cur_lvl, flags, evt;
  logic              loop_on, stat_rd;

  mdm_hs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .ctrl_q(ctrl_q),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
    .loop_on(loop_on), .loop_lvl(loop_lvl)
  );

  mdm_hs_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({dcd_n, ri_n, dsr_n, cts_n}), .q(ext_sync_n)
  );

  assign cur_lvl = loop_on ? loop_lvl : pin_level(ext_sync_n);
  assign stat_rd = rd_en & rd_sel;

  mdm_hs_delta u_delta (
    .clk(clk), .rst_n(rst_n), .cur_lvl(cur_lvl), .rd_clr(stat_rd),
    .flags(flags), .evt(evt)
  );

  assign rdata   = rd_sel ? {cur_lvl, flags} : ctrl_q;
  assign loop_en = loop_on;
  assign chg_irq = |flags;

  AST_EVENT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> chg_irq); // R8
endmodule

// File: tb/sim_mdm_hs_regs.sv
`timescale 1ns/1ps
module sim_mdm_hs_regs;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, rd_sel = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic dtr_n, rts_n, out1_n, out2_n, loop_en, chg_irq;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  int n_run = 0, n_fail = 0;

  typedef struct { logic [7:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q[$];
  event rd_evt;

  always #2.5 clk = ~clk;

  mdm_hs_regs u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rd_sel(rd_sel),
    .wdata(wdata), .rdata(rdata), .dtr_n(dtr_n), .rts_n(rts_n),
    .out1_n(out1_n), .out2_n(out2_n), .loop_en(loop_en),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n), .chg_irq(chg_irq)
  );

  // Status byte as the requirements define it: levels {DCD,RI,DSR,CTS} over flags.
  function automatic logic [7:0] stat(input logic dcd, ri, dsr, cts, input logic [3:0] fl);
    return {dcd, ri, dsr, cts, fl};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each read strobe.
  initial forever begin
    sb_item_t it;
    @(rd_evt);
    #1;
    it = sb_q.pop_front();
    chk(it.tag, rdata, it.exp);
  end

  task automatic rd(input logic sel, input logic [7:0] exp, input string tag);
    sb_item_t it;
    @(negedge clk);
    rd_en = 1; rd_sel = sel;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    ->rd_evt;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R9 reset state
    chk("R9 pins", {4'h0, dtr_n, rts_n, out1_n, out2_n}, 8'h0F);
    chk("R9 irq", {7'h0, chg_irq}, 8'h00);
    rd(0, 8'h00, "R9 ctrl");
    rd(1, 8'h00, "R9 status");

    // R1 reserved bits dropped; R2 all outputs active
    wr(8'hEF);
    rd(0, 8'h0F, "R1 readback");
    chk("R2 pins all", {4'h0, dtr_n, rts_n, out1_n, out2_n, loop_en} >> 1, 8'h00);
    chk("R2 loop_en", {7'h0, loop_en}, 8'h00);
    wr(8'h01);
    chk("R2 dtr only", {6'h0, dtr_n, rts_n}, 8'h01);

    // R4 R5 R8 CTS assertion
    cts_n = 0; idle(4);
    chk("R8 irq set", {7'h0, chg_irq}, 8'h01);
    rd(1, stat(0,0,0,1,4'b0001), "R4 R5 cts");
    rd(1, stat(0,0,0,1,4'b0000), "R7 cleared");
    chk("R8 irq clear", {7'h0, chg_irq}, 8'h00);

    // R5 DSR double toggle stays flagged
    dsr_n = 0; idle(3); dsr_n = 1; idle(4);
    rd(1, stat(0,0,0,1,4'b0010), "R5 dsr sticky");

    // R6 ring assertion does not flag, release does
    ri_n = 0; idle(4);
    rd(1, stat(0,1,0,1,4'b0000), "R6 ring lead");
    ri_n = 1; idle(4);
    rd(1, stat(0,0,0,1,4'b0100), "R6 ring trail");

    // R5 DCD
    dcd_n = 0; idle(4);
    rd(1, stat(1,0,0,1,4'b1000), "R5 dcd");
    dcd_n = 1; idle(4);
    rd(1, stat(0,0,0,1,4'b1000), "R5 dcd drop");

    // R7 change lands in the read-clear cycle
    @(negedge clk); cts_n = 1;
    @(negedge clk);
    rd(1, stat(0,0,0,0,4'b0000), "R7 race read");
    rd(1, stat(0,0,0,0,4'b0001), "R7 race kept");

    // R3 loopback: RTS and OUT1 on
    wr(8'h16);
    chk("R3 pins held", {6'h0, dtr_n, rts_n}, 8'h03);
    chk("R3 out1 follows", {7'h0, out1_n}, 8'h00);
    chk("R2 loop_en on", {7'h0, loop_en}, 8'h01);
    idle(2);
    rd(1, stat(0,1,0,1,4'b0001), "R3 loop levels");
    dsr_n = 0; idle(4);
    rd(1, stat(0,1,0,1,4'b0000), "R3 ext ignored");
    wr(8'h12);
    idle(2);
    rd(1, stat(0,0,0,1,4'b0100), "R3 loop ring trail");
    wr(8'h00);
    idle(2);
    rd(1, stat(0,0,1,0,4'b0011), "R3 exit loop");

    idle(3);
    finish_run();
  end
endmodule